// File: doc/BRIEF.md
# Interlaced YUV Video Output Sequencer

This block produces the byte-wide component stream and the active-low sync strobes that an external TV encoder needs for interlaced video. It asks a simple valid/ready pixel source for components in the order U, Y, V, Y and emits one 8-bit component per clock of the nominal 27 MHz pixel clock. Clocks per line are split into a blanking part and an active part. Lines per field and the length of the vertical sync pulse are set by parameters.

Every line begins with a one-cycle low pulse on horizontal sync. Every field begins with a falling edge on vertical sync. An odd field, which is the first field of a frame, has its vertical sync edge in the same cycle as a horizontal sync edge. An even field has its vertical sync edge half a line later, so the two edges never coincide. The encoder uses this placement to tell the two fields apart.

The active window is the stretch of clocks in each line where the block requests data. In that window a clock with source data drives the component and pulls data-ready low. A clock with no source data keeps the bus at zero, leaves data-ready high and raises an underrun flag.

Top module: `ileave_video_seq`

## Requirements
- R1: During and immediately after reset, hsync_n, vsync_n and drdy_n are high, data_out and underrun are 0. The first output cycle after reset is an odd-field start: hsync_n and vsync_n fall in the same cycle.
- R2: With line position h counting 0..LINE_CYC-1 (LINE_CYC = ACTIVE_CYC + BLANK_CYC), hsync_n is low for exactly one cycle per line, in the output cycle of position 0. It is high otherwise.
- R3: vsync_n falls once per field (every LINES_PER_FIELD lines) and stays low for exactly VS_LOW_CYC cycles.
- R4: For an odd field, vsync_n falls in the same cycle as hsync_n falls, on the first line of the field.
- R5: For an even field, vsync_n falls LINE_CYC/2 cycles after the hsync_n falling edge of the field's first line, and never together with a hsync_n edge.
- R6: Fields alternate odd, even, odd, even, starting with odd after reset.
- R7: in_ready is high exactly in the active positions h = BLANK_CYC..LINE_CYC-1. Outside them, including the hsync_n low cycle, data_out is 0 and drdy_n is high.
- R8: A cycle with in_ready and in_valid both high is a transfer. In the next cycle data_out equals the transferred in_data and drdy_n is low.
- R9: A cycle with in_ready high and in_valid low is an underrun. In the next cycle underrun is 1, drdy_n is high and data_out is 0. underrun is 0 in every other cycle.
- R10: comp_sel names the requested component (0 = U, 1 = Y, 2 = V). It steps through U, Y, V, Y, advancing once per transfer, and returns to U at the start of every line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Source has a component available |
| in_data | input | DATA_W | Component value from the source |
| in_ready | output | 1 | Sequencer takes a component this cycle (active window) |
| comp_sel | output | 2 | Component requested: 0 = U, 1 = Y, 2 = V |
| data_out | output | DATA_W | Component byte to the encoder, zero when idle |
| hsync_n | output | 1 | Horizontal sync, active low, one cycle per line |
| vsync_n | output | 1 | Vertical sync, active low, once per field |
| drdy_n | output | 1 | Data-ready, low when data_out carries a component |
| underrun | output | 1 | Active cycle with no source data |

## Verification
The hardest case to reach is the even-field vertical sync. Its falling edge sits in the middle of a line, so the bench has to run through a whole field before it can be seen. It must then come back with the opposite placement on the next field, together with source stalls that interrupt the U, Y, V, Y order. The bench runs several whole frames with small default parameters and changes the source pattern along the way: always valid, a pseudo-random stall pattern, and a fully starved stretch. It also pulls reset in the middle of a field, so the odd-first restart is exercised from an arbitrary state.

// File: rtl/tvs_pkg.sv
// Shared types for the interlaced video output sequencer.
package tvs_pkg;
    // Component code presented on comp_sel.
    typedef enum logic [1:0] {
        COMP_U = 2'd0,
        COMP_Y = 2'd1,
        COMP_V = 2'd2
    } comp_e;
endpackage

// File: rtl/tvs_line_timer.sv
// Line timer: counts pixel clocks within a line and decodes line start,
// mid-line and the active window. Assumes BLANK_CYC >= 2, ACTIVE_CYC >= 1.
module tvs_line_timer #(
    parameter int ACTIVE_CYC = 16,
    parameter int BLANK_CYC  = 6,
    localparam int LINE_CYC  = ACTIVE_CYC + BLANK_CYC,
    localparam int HW        = $clog2(LINE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic line_start,
    output logic line_end,
    output logic mid_line,
    output logic active
);
    localparam int HALF = LINE_CYC / 2;

    logic [HW-1:0] h_cnt;

    // Advance the position in the line, wrapping at the line length.
    always_ff @(posedge clk) begin
        if (!rst_n)        h_cnt <= '0;
        else if (line_end) h_cnt <= '0;
        else               h_cnt <= h_cnt + 1'b1;
    end

    // Decode positions of interest.
    always_comb begin
        line_start = (h_cnt == '0);
        line_end   = (h_cnt == HW'(LINE_CYC - 1));
        mid_line   = (h_cnt == HW'(HALF));
        active     = (h_cnt >= HW'(BLANK_CYC));
    end
endmodule

// File: rtl/tvs_field_timer.sv
// Field timer: counts lines per field, tracks field parity and produces
// the vertical sync low window. Odd fields start the pulse at line start,
// even fields at mid-line of the first line. Assumes VS_LOW_CYC >= 1.
module tvs_field_timer #(
    parameter int LINES_PER_FIELD = 5,
    parameter int VS_LOW_CYC      = 3,
    localparam int VW             = $clog2(LINES_PER_FIELD + 1),
    localparam int SW             = $clog2(VS_LOW_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic line_end,
    input  logic mid_line,
    output logic vs_low,
    output logic field_odd
);
    logic [VW-1:0] v_cnt;
    logic [SW-1:0] vs_left;
    logic          first_line;
    logic          vs_event;

    // Count lines and flip parity at each field boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_cnt     <= '0;
            field_odd <= 1'b1;
        end else if (line_end) begin
            if (v_cnt == VW'(LINES_PER_FIELD - 1)) begin
                v_cnt     <= '0;
                field_odd <= ~field_odd;
            end else begin
                v_cnt <= v_cnt + 1'b1;
            end
        end
    end

    // Pick the cycle in which the field's vertical sync begins.
    always_comb begin
        first_line = (v_cnt == '0);
        vs_event   = first_line && (field_odd ? line_start : mid_line);
    end

    // Hold vertical sync low for the remaining cycles of the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)              vs_left <= '0;
        else if (vs_event)       vs_left <= SW'(VS_LOW_CYC - 1);
        else if (vs_left != '0)  vs_left <= vs_left - 1'b1;
    end

    // Vertical sync is low at the event and while the remainder runs.
    assign vs_low = vs_event || (vs_left != '0);
endmodule

// File: rtl/tvs_comp_seq.sv
// Component sequencer: steps U, Y, V, Y once per accepted component and
// returns to U at every line start.
module tvs_comp_seq
    import tvs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  line_start,
    input  logic  xfer,
    output comp_e comp_sel
);
    logic [1:0] idx;

    // Advance the position in the four-step order.
    always_ff @(posedge clk) begin
        if (!rst_n)          idx <= '0;
        else if (line_start) idx <= '0;
        else if (xfer)       idx <= idx + 1'b1;
    end

    // Odd positions are luma, even positions alternate U and V.
    always_comb begin
        if (idx[0])      comp_sel = COMP_Y;
        else if (idx[1]) comp_sel = COMP_V;
        else             comp_sel = COMP_U;
    end
endmodule

// File: rtl/ileave_video_seq.sv
// Top of the interlaced video output sequencer. Combines the line timer,
// field timer and component sequencer and registers every encoder-side
// output, so that all strobes and data leave the block aligned.
// Assumes BLANK_CYC >= 2 and VS_LOW_CYC < LINE_CYC / 2.
module ileave_video_seq
    import tvs_pkg::*;
#(
    parameter int DATA_W          = 8,
    parameter int ACTIVE_CYC      = 16,
    parameter int BLANK_CYC       = 6,
    parameter int LINES_PER_FIELD = 5,
    parameter int VS_LOW_CYC      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic [1:0]        comp_sel,
    output logic [DATA_W-1:0] data_out,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              drdy_n,
    output logic              underrun
);
    logic  line_start, line_end, mid_line, active;
    logic  vs_low, field_odd;
    logic  xfer;
    comp_e comp_w;

    tvs_line_timer #(
        .ACTIVE_CYC (ACTIVE_CYC),
        .BLANK_CYC  (BLANK_CYC)
    ) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .line_end   (line_end),
        .mid_line   (mid_line),
        .active     (active)
    );

    tvs_field_timer #(
        .LINES_PER_FIELD (LINES_PER_FIELD),
        .VS_LOW_CYC      (VS_LOW_CYC)
    ) u_field (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .line_end   (line_end),
        .mid_line   (mid_line),
        .vs_low     (vs_low),
        .field_odd  (field_odd)
    );

    tvs_comp_seq u_comp (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .xfer       (xfer),
        .comp_sel   (comp_w)
    );

    // Accept a component whenever the window is open and the source has one.
    always_comb begin
        in_ready = active;
        xfer     = active && in_valid;
        comp_sel = comp_w;
    end

    // Register the encoder-side strobes and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_n  <= 1'b1;
            vsync_n  <= 1'b1;
            drdy_n   <= 1'b1;
            underrun <= 1'b0;
            data_out <= '0;
        end else begin
            hsync_n  <= ~line_start;
            vsync_n  <= ~vs_low;
            drdy_n   <= ~xfer;
            underrun <= active && !in_valid;
            data_out <= xfer ? in_data : '0;
        end
    end
endmodule

// File: rtl/ileave_video_seq_chk.sv
// Checker for the interlaced video output sequencer, observing ports only.
// Holds small counters for the hsync age and vsync width windows.
module ileave_video_seq_chk #(
    parameter int DATA_W          = 8,
    parameter int ACTIVE_CYC      = 16,
    parameter int BLANK_CYC       = 6,
    parameter int VS_LOW_CYC      = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              in_ready,
    input logic [1:0]        comp_sel,
    input logic [DATA_W-1:0] data_out,
    input logic              hsync_n,
    input logic              vsync_n,
    input logic              drdy_n,
    input logic              underrun
);
    localparam int LINE_CYC = ACTIVE_CYC + BLANK_CYC;
    localparam int HALF     = LINE_CYC / 2;

    logic [15:0] hs_age;
    logic [15:0] vs_run;

    // Cycles since the last hsync low cycle, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              hs_age <= '0;
        else if (!hsync_n)       hs_age <= 16'd1;
        else if (hs_age != '1)   hs_age <= hs_age + 1'b1;
    end

    // Length of the current vsync low run.
    always_ff @(posedge clk) begin
        if (!rst_n)        vs_run <= '0;
        else if (!vsync_n) vs_run <= vs_run + 1'b1;
        else               vs_run <= '0;
    end

    p_hs_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |=> hsync_n);

    p_vs_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_n) |-> vs_run == 16'(VS_LOW_CYC));

    p_vs_place_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n) |-> (!hsync_n || (hs_age == 16'(HALF))));

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drdy_n |-> data_out == '0);

    p_ready_off_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> hsync_n);

    p_xfer_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> (!drdy_n && data_out == $past(in_data)));

    p_underrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> (underrun && drdy_n));

    p_no_false_underrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && !in_valid) |=> !underrun);

    p_line_begins_u_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> comp_sel == 2'd0);
endmodule

bind ileave_video_seq ileave_video_seq_chk #(
    .DATA_W     (DATA_W),
    .ACTIVE_CYC (ACTIVE_CYC),
    .BLANK_CYC  (BLANK_CYC),
    .VS_LOW_CYC (VS_LOW_CYC)
) u_chk (.*);

// File: tb/test_ileave_video_seq.sv
// Bench for the interlaced video output sequencer: a behavioural model of
// line/field position, compared with the outputs on every clock.
module test_ileave_video_seq;
    localparam int DW    = 8;
    localparam int ACT   = 16;
    localparam int BLANK = 6;
    localparam int LINES = 5;
    localparam int VSL   = 3;
    localparam int LINE  = ACT + BLANK;
    localparam int HALF  = LINE / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic [1:0]    comp_sel;
    logic [DW-1:0] data_out;
    logic          hsync_n, vsync_n, drdy_n, underrun;

    int errors = 0;
    int checks = 0;

    ileave_video_seq #(
        .DATA_W (DW), .ACTIVE_CYC (ACT), .BLANK_CYC (BLANK),
        .LINES_PER_FIELD (LINES), .VS_LOW_CYC (VSL)
    ) i_ileave_video_seq (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
        .in_ready (in_ready), .comp_sel (comp_sel), .data_out (data_out),
        .hsync_n (hsync_n), .vsync_n (vsync_n), .drdy_n (drdy_n),
        .underrun (underrun)
    );

    always #10 clk = ~clk;

    // Model state: position within line and field, parity, pulse remainder.
    int h = 0, v = 0, idx = 0, vl = 0;
    bit odd = 1'b1;
    bit started = 1'b0;
    bit e_hs = 1, e_vs = 1, e_dr = 1, e_u = 0;
    logic [DW-1:0] e_d = '0;
    int ev_kind = 0;

    always @(posedge clk) begin
        bit act, ev, xf;
        started = 1'b1;
        if (!rst_n) begin
            h = 0; v = 0; idx = 0; vl = 0; odd = 1'b1; ev_kind = 0;
            e_hs = 1; e_vs = 1; e_dr = 1; e_u = 0; e_d = '0;
        end else begin
            act = (h >= BLANK);
            ev  = (v == 0) && (odd ? (h == 0) : (h == HALF));
            xf  = act && in_valid;
            ev_kind = ev ? (odd ? 1 : 2) : 0;
            e_hs = (h != 0);
            e_vs = !(ev || vl > 0);
            e_dr = !xf;
            e_u  = act && !in_valid;
            e_d  = xf ? in_data : '0;
            if (h == 0) idx = 0;
            if (xf) idx = (idx + 1) % 4;
            vl = ev ? VSL - 1 : (vl > 0 ? vl - 1 : 0);
            h = h + 1;
            if (h == LINE) begin
                h = 0; v = v + 1;
                if (v == LINES) begin v = 0; odd = !odd; end
            end
        end
    end

    function automatic int order_code(int i);
        return (i % 2 == 1) ? 1 : (i == 2 ? 2 : 0);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act_v, exp_v);
        end
    endtask

    // Observed field-start tracking for alternation and placement.
    bit prev_vs = 1'b1;
    int last_kind = 0;
    int odd_seen = 0, even_seen = 0;
    int age = 0;

    // Compare every output away from the clock edge.
    always @(negedge clk) begin
        if (started) begin
            string vreq;
            vreq = (ev_kind == 1) ? "R4" : (ev_kind == 2) ? "R5" : "R3";
            chk(hsync_n == e_hs, "R2", "hsync_n", hsync_n, e_hs);
            chk(vsync_n == e_vs, vreq, "vsync_n", vsync_n, e_vs);
            chk(drdy_n == e_dr, "R8", "drdy_n", drdy_n, e_dr);
            chk(data_out == e_d, "R8", "data_out", data_out, e_d);
            chk(underrun == e_u, "R9", "underrun", underrun, e_u);
            if (rst_n) begin
                chk(in_ready == (h >= BLANK), "R7", "in_ready", in_ready, h >= BLANK);
                chk(comp_sel == 2'(order_code(idx)), "R10", "comp_sel",
                    comp_sel, order_code(idx));
            end
            if (!rst_n) begin
                prev_vs = 1'b1; last_kind = 0; age = 0;
            end else begin
                if (prev_vs && !vsync_n) begin
                    int kind;
                    kind = !hsync_n ? 1 : 2;
                    if (kind == 2)
                        chk(age == HALF, "R5", "even vsync offset", age, HALF);
                    if (last_kind == 0)
                        chk(kind == 1, "R1", "first field kind", kind, 1);
                    else
                        chk(kind != last_kind, "R6", "field alternation", kind, 3 - last_kind);
                    if (kind == 1) odd_seen++; else even_seen++;
                    last_kind = kind;
                end
                age = !hsync_n ? 1 : age + 1;
                prev_vs = vsync_n;
            end
        end
    end

    bit done = 1'b0;

    // Stimulus: reset, then several source patterns over whole frames.
    initial begin
        logic [7:0] lfsr;
        lfsr = 8'hA5;
        repeat (3) @(negedge clk);
        chk(hsync_n && vsync_n && drdy_n && !underrun && data_out == 0,
            "R1", "reset outputs", {hsync_n, vsync_n, drdy_n}, 7);
        rst_n = 1'b1;
        for (int c = 0; c < 1800; c++) begin
            @(negedge clk);
            in_data = in_data + 8'd7;
            if (c < 500)       in_valid = 1'b1;
            else if (c < 1000) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                in_valid = lfsr[0];
            end
            else if (c < 1100) in_valid = 1'b0;
            else if (c == 1237) begin
                rst_n = 1'b0;
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
            end
            else               in_valid = (c % 3 != 0);
        end
        @(negedge clk);
        chk(odd_seen >= 3, "R4", "odd field starts seen", odd_seen, 3);
        chk(even_seen >= 3, "R5", "even field starts seen", even_seen, 3);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule